// File: doc/BRIEF.md
# Non-Maskable Interrupt Pending Controller

This block connects a raw non-maskable interrupt pin to a processor core's interrupt sequencer. The pin is synchronized and edge-detected. Each rising edge becomes one request to the core, tagged with a vector of 2 that is generated inside the block. The core takes the request through a valid/accept handshake, and no external acknowledge transaction is produced. After the core accepts a request, the block treats a handler as running until the core pulses a return-from-handler strobe.

While a handler is running, at most one new edge is held back. That edge is presented in the cycle after the return strobe, and any further edges in the meantime are discarded.

When the local interrupt controller is enabled, the pin stops feeding the non-maskable path. Its synchronized level is then sent to a separate local-interrupt output. A strap input is sampled on the first clock edge after reset is released. If the strap is low, the local interrupt controller is locked as hardware disabled, and the pin always uses the non-maskable path.

Top module: `nmi_pend_ctrl`

## Requirements
- R1: Only a rising edge of `nmi_i`, seen after a two-stage synchronizer, creates a request, and each edge creates exactly one. A level held high creates no further request after the first.
- R2: While `req_valid_o` is high, `req_vector_o` equals 2.
- R3: An edge that arrives while a handler is in service is held. `req_valid_o` stays low until `hret_i` is pulsed, and the held request is presented in the cycle after that pulse.
- R4: Only one request can be held. Further edges that arrive while one is already held are discarded.
- R5: If `hret_i` and a new synchronized rising edge occur in the same cycle, the edge is kept and presented in the next cycle.
- R6: In local mode (`lapic_en_i` = 1 and not hardware disabled), `lint_o` follows the synchronized input and no request is raised from it. Otherwise `lint_o` is 0.
- R7: If `strap_i` is 0 on the first clock edge after reset release, the local controller is hardware disabled. In that case `lapic_en_i` has no effect, `lint_o` stays 0, and edges raise requests.
- R8: Reset clears the held request, the in-service flag and the edge history. `req_valid_o` is 0 during reset and stays 0 after it until a new edge arrives.
- R9: When `req_valid_o` and `req_accept_i` are both high on a clock edge, the handler is in service, and `req_valid_o` is low from the next cycle until `hret_i`.
- R10: Once presented, a request stays valid until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Raw interrupt pin, asynchronous |
| strap_i | input | 1 | Strap sampled after reset release; 0 disables local controller |
| lapic_en_i | input | 1 | Local interrupt controller enable |
| req_valid_o | output | 1 | Request to the core |
| req_vector_o | output | VEC_W | Vector of the request, fixed at 2 |
| req_accept_i | input | 1 | Core takes the request |
| hret_i | input | 1 | Return-from-handler strobe |
| lint_o | output | 1 | Local-interrupt line in local mode |

## Verification
The assertions check the following on every cycle: the fixed vector, that a request stays valid until it is accepted, that accepting a request silences the output, that a new request appears only after a synchronized edge or a return strobe, and that a hardware-disabled controller never drives the local line. Other behaviour needs the bench's scenarios to show it. These are: discarding a second edge during a handler, keeping an edge that coincides with the return strobe, ignoring a held-high level, the strap lockout across a reset, and the loss of a pending request to reset.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int VEC_W       = 8;
  localparam int NMI_VEC     = 2;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[0] <= 1'b0;
          else         q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) q[i] <= 1'b0;
          else         q[i] <= q[i-1];
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/nmi_rise_det.sv
module nmi_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= lvl_i;

  assign rise_o = lvl_i & ~hist_q;
endmodule

// File: rtl/nmi_strap_latch.sv
module nmi_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic hw_dis_o
);
  logic done_q, dis_q;

  // capture once, on the first edge after reset release; disabled until then
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      done_q <= 1'b0;
      dis_q  <= 1'b1;
    end else if (!done_q) begin
      done_q <= 1'b1;
      dis_q  <= ~strap_i;
    end

  assign hw_dis_o = dis_q;
endmodule

// File: rtl/nmi_track.sv
module nmi_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic accept_i,
  input  logic hret_i,
  output logic valid_o,
  output logic insvc_o
);
  logic pend_q, insvc_q, take;

  assign valid_o = pend_q & ~insvc_q;
  assign take    = valid_o & accept_i;
  assign insvc_o = insvc_q;

  // new edge wins over clearing, so an edge on the accept or return cycle is kept
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pend_q <= 1'b0;
    else if (rise_i) pend_q <= 1'b1;
    else if (take)   pend_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      insvc_q <= 1'b0;
    else if (take)    insvc_q <= 1'b1;
    else if (hret_i)  insvc_q <= 1'b0;
endmodule

// File: rtl/nmi_pend_ctrl.sv
module nmi_pend_ctrl #(
  parameter int VEC_W       = nmi_pkg::VEC_W,
  parameter int SYNC_STAGES = nmi_pkg::SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             strap_i,
  input  logic             lapic_en_i,
  output logic             req_valid_o,
  output logic [VEC_W-1:0] req_vector_o,
  input  logic             req_accept_i,
  input  logic             hret_i,
  output logic             lint_o
);
  logic nmi_lvl, lvl_rise, nmi_rise, hw_dis, local_mode, insvc;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nmi_i), .q_o(nmi_lvl)
  );

  nmi_rise_det u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(nmi_lvl), .rise_o(lvl_rise)
  );

  nmi_strap_latch u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .hw_dis_o(hw_dis)
  );

  assign local_mode = lapic_en_i & ~hw_dis;
  assign nmi_rise   = lvl_rise & ~local_mode;
  assign lint_o     = nmi_lvl & local_mode;

  nmi_track u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(nmi_rise),
    .accept_i(req_accept_i), .hret_i(hret_i),
    .valid_o(req_valid_o), .insvc_o(insvc)
  );

  assign req_vector_o = VEC_W'(nmi_pkg::NMI_VEC);
endmodule

// File: rtl/nmi_pend_ctrl_chk.sv
module nmi_pend_ctrl_chk #(
  parameter int VEC_W = nmi_pkg::VEC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic [VEC_W-1:0] req_vector_o,
  input logic             req_accept_i,
  input logic             hret_i,
  input logic             lint_o,
  input logic             nmi_rise,
  input logic             hw_dis
);
  AST_VEC_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_vector_o == VEC_W'(nmi_pkg::NMI_VEC)); // R2

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_accept_i |=> req_valid_o); // R10

  AST_ACCEPT_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_accept_i |=> !req_valid_o); // R9

  AST_RISE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(nmi_rise) || $past(hret_i)); // R3

  AST_HWDIS_NO_LINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_dis |-> !lint_o); // R7
endmodule

bind nmi_pend_ctrl nmi_pend_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_o(req_valid_o),
  .req_vector_o(req_vector_o), .req_accept_i(req_accept_i), .hret_i(hret_i),
  .lint_o(lint_o), .nmi_rise(nmi_rise), .hw_dis(hw_dis)
);

// File: tb/nmi_pend_ctrl_tb.sv
module nmi_pend_ctrl_tb;
  localparam int VW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 1'b0, strap = 1'b1, lapic_en = 1'b0, acc = 1'b1, hret = 1'b0;
  logic req_valid, lint;
  logic [VW-1:0] req_vec;
  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  nmi_pend_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .strap_i(strap),
    .lapic_en_i(lapic_en), .req_valid_o(req_valid), .req_vector_o(req_vec),
    .req_accept_i(acc), .hret_i(hret), .lint_o(lint)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ret_pulse();
    @(negedge clk) hret = 1'b1;
    @(negedge clk) hret = 1'b0;
  endtask

  // delivers one request that is expected, leaves handler in service
  task automatic edge_delivered();
    exp_q.push_back(2);
    @(negedge clk) nmi = 1'b1;
    wait_n(5);
    nmi = 1'b0;
    wait_n(3);
  endtask

  // monitor: scoreboard pops on every handshake
  always @(negedge clk) begin
    if (rst_n && req_valid && acc) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected delivery", 1, 0);
      else chk(int'(req_vec) == exp_q.pop_front(), "R2 vector", int'(req_vec), 2);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_n(1);
    chk(req_valid == 1'b0, "R8 valid in reset", int'(req_valid), 0);
    wait_n(2);
    rst_n = 1'b1;
    wait_n(2);
    chk(req_valid == 1'b0 && lint == 1'b0, "R8 reset state", int'(req_valid), 0);

    // R1/R2/R9: single edge, then level held high
    exp_q.push_back(2);
    @(negedge clk) nmi = 1'b1;
    wait_n(5);
    chk(exp_q.size() == 0, "R1 edge delivered", exp_q.size(), 0);
    chk(req_valid == 1'b0, "R9 in service silences", int'(req_valid), 0);
    ret_pulse();
    wait_n(8);
    chk(req_valid == 1'b0, "R1 held level no retrigger", int'(req_valid), 0);
    nmi = 1'b0;
    wait_n(4);

    // R3/R4: two edges during service, one kept
    edge_delivered();
    exp_q.push_back(2);
    @(negedge clk) nmi = 1'b1;
    wait_n(5); nmi = 1'b0; wait_n(3);
    @(negedge clk) nmi = 1'b1;
    wait_n(5); nmi = 1'b0; wait_n(3);
    chk(req_valid == 1'b0, "R3 held during service", int'(req_valid), 0);
    chk(exp_q.size() == 1, "R3 not yet delivered", exp_q.size(), 1);
    @(negedge clk) hret = 1'b1;
    @(negedge clk) hret = 1'b0;
    chk(req_valid == 1'b1, "R3 presented after return", int'(req_valid), 1);
    wait_n(2);
    ret_pulse();
    wait_n(5);
    chk(req_valid == 1'b0, "R4 extra edge discarded", int'(req_valid), 0);
    chk(exp_q.size() == 0, "R4 delivery count", exp_q.size(), 0);

    // R5: return and edge in the same cycle
    edge_delivered();
    exp_q.push_back(2);
    @(negedge clk) nmi = 1'b1;
    wait_n(2);
    hret = 1'b1;
    @(negedge clk) hret = 1'b0;
    chk(req_valid == 1'b1, "R5 coincident edge kept", int'(req_valid), 1);
    wait_n(2);
    ret_pulse();
    nmi = 1'b0;
    wait_n(4);
    chk(exp_q.size() == 0, "R5 delivered", exp_q.size(), 0);

    // R6: local mode
    lapic_en = 1'b1;
    wait_n(2);
    @(negedge clk) nmi = 1'b1;
    wait_n(3);
    chk(lint == 1'b1, "R6 lint follows input", int'(lint), 1);
    wait_n(3);
    chk(req_valid == 1'b0, "R6 no request in local mode", int'(req_valid), 0);
    nmi = 1'b0;
    wait_n(4);
    chk(lint == 1'b0, "R6 lint low", int'(lint), 0);
    lapic_en = 1'b0;
    wait_n(2);

    // R8: reset drops a pending request
    acc = 1'b0;
    @(negedge clk) nmi = 1'b1;
    wait_n(5);
    chk(req_valid == 1'b1, "R10 waits for accept", int'(req_valid), 1);
    nmi = 1'b0;
    strap = 1'b0;
    rst_n = 1'b0;
    wait_n(1);
    chk(req_valid == 1'b0, "R8 reset clears pending", int'(req_valid), 0);
    wait_n(2);
    rst_n = 1'b1;
    wait_n(5);
    chk(req_valid == 1'b0, "R8 nothing after reset", int'(req_valid), 0);
    acc = 1'b1;

    // R7: strap low, local enable ignored
    lapic_en = 1'b1;
    exp_q.push_back(2);
    @(negedge clk) nmi = 1'b1;
    wait_n(3);
    chk(lint == 1'b0, "R7 lint stays low", int'(lint), 0);
    wait_n(3);
    chk(exp_q.size() == 0, "R7 edge uses nmi path", exp_q.size(), 0);
    nmi = 1'b0;
    ret_pulse();
    wait_n(4);
    chk(exp_q.size() == 0 && req_valid == 1'b0, "R1 final scoreboard", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule